// File: doc/BRIEF.md
# Coupled-Register Bit-Serial Keystream Generator

This core produces a pseudorandom keystream one bit at a time from an 80-bit key and a 64-bit IV. It keeps two 80-stage shift registers. One register has linear feedback. The other has nonlinear feedback, and that feedback is masked by the head bit of the linear register. A five-input filter of algebraic degree 3 takes inputs from both registers. Its output is XORed with seven taps of the nonlinear register to form each keystream bit.

After an accepted start, the core loads the key and IV. It then runs a fixed warm-up of 160 steps. During each of these steps the keystream bit is fed back into both registers and nothing is emitted. After the warm-up the core offers bits on a valid/ready handshake. It advances only when a bit is taken. The stream continues until reset, or until a new start re-keys the core.

Top module: `kstream80_gen`

## Requirements
- R1: A synchronous active-high reset brings the core to idle: `valid_o` and `busy_o` are low, and they stay low until a start is accepted.
- R2: On an accepted start, the nonlinear register stage k takes `key_i[k]` for k = 0..79. Linear register stage k takes `iv_i[k]` for k = 0..63. Linear stages 64..79 are set to one.
- R3: The linear register feedback is the XOR of stages 0, 13, 23, 38, 51 and 62.
- R4: The nonlinear register feedback is linear stage 0 XOR b0^b9^b14^b21^b28^b33^b37^b45^b52^b60^b62 XOR the products b9b15, b33b37, b60b63, b21b28b33, b45b52b60, b15b21b60b63, b33b37b52b60, b9b28b45b63, b9b15b21b28b33, b37b45b52b60b63 and b21b28b33b37b45b52.
- R5: `bit_o` = h(s3, s25, s46, s64, b63) XOR b1^b2^b4^b10^b31^b43^b56. Here h(x0..x4) = x1^x4^x0x3^x2x3^x3x4^x0x1x2^x0x2x3^x0x2x4^x1x2x4^x2x3x4. The letter s names linear stages and b names nonlinear stages.
- R6: After the start edge, `busy_o` is high and `valid_o` is low for exactly 160 cycles. In each of these cycles the core advances with the current keystream bit XORed into both feedback inputs. After that, `valid_o` is high and `busy_o` is low.
- R7: In keystream mode, both registers advance only in a cycle where `valid_o` and `ready_i` are both high. When `ready_i` is low, the state and `bit_o` hold.
- R8: A start during the warm-up is ignored, including one in its last cycle, and its key and IV are not sampled.
- R9: A start in keystream mode is accepted and re-keys the core, even when a handshake completes in the same cycle.
- R10: Each step shifts both registers toward stage 0, and the new bit enters at stage 79.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Load key/IV and begin warm-up (ignored while busy) |
| key_i | input | 80 | Key, bit k to nonlinear stage k |
| iv_i | input | 64 | IV, bit k to linear stage k |
| ready_i | input | 1 | Consumer takes the current bit |
| busy_o | output | 1 | Warm-up in progress |
| valid_o | output | 1 | `bit_o` carries a keystream bit |
| bit_o | output | 1 | Keystream bit |

## Verification
Two functions can fall in the same cycle. A start can coincide with a completed handshake in keystream mode. A start can also arrive on the final warm-up cycle, where the core is about to move into keystream mode. The bench drives the first case by raising start, new key material and ready together on a valid bit. It checks that bit against the model, then checks that the following stream matches a model loaded with the new key. For the second case, and for starts earlier in the warm-up, the bench offers a different key. It judges the result by the stream matching the original key, with valid rising exactly 160 cycles after the accepted start.

// File: rtl/kgen_pkg.sv
package kgen_pkg;
  typedef enum logic [1:0] {PH_IDLE, PH_WARM, PH_RUN} phase_t;
  localparam int unsigned MASK_N = 7;
  localparam int unsigned MASK_AT [MASK_N] = '{1, 2, 4, 10, 31, 43, 56};
endpackage

// File: rtl/kg_lin_reg.sv
module kg_lin_reg #(
  parameter int unsigned W    = 80,
  parameter int unsigned IV_W = 64
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load,
  input  logic            adv,
  input  logic            inject,
  input  logic [IV_W-1:0] iv_i,
  output logic            head_o,
  output logic [3:0]      taps_o
);
  localparam int unsigned PAD_W = W - IV_W;

  logic [W-1:0] s_q;
  logic         fb;

  assign fb     = s_q[62] ^ s_q[51] ^ s_q[38] ^ s_q[23] ^ s_q[13] ^ s_q[0] ^ inject;
  assign head_o = s_q[0];
  assign taps_o = {s_q[64], s_q[46], s_q[25], s_q[3]};

  always_ff @(posedge clk) begin
    if (rst)       s_q <= '0;
    else if (load) s_q <= {{PAD_W{1'b1}}, iv_i};
    else if (adv)  s_q <= {fb, s_q[W-1:1]};
  end

  AST_PAD_ONES: assert property (@(posedge clk) disable iff (rst)
    load |=> (s_q[W-1:IV_W] == {PAD_W{1'b1}})); // R2
  AST_LIN_SHIFT: assert property (@(posedge clk) disable iff (rst)
    (adv && !load) |=> (s_q[W-2:0] == $past(s_q[W-1:1]))); // R10
endmodule

// File: rtl/kg_nl_reg.sv
module kg_nl_reg
  import kgen_pkg::*;
#(
  parameter int unsigned W = 80
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              adv,
  input  logic              inject,
  input  logic              lin_head_i,
  input  logic [W-1:0]      key_i,
  output logic              fltr_tap_o,
  output logic [MASK_N-1:0] mask_o
);
  logic [W-1:0] b_q;
  logic         lin_part, prod_part, fb;

  assign lin_part = b_q[0] ^ b_q[9] ^ b_q[14] ^ b_q[21] ^ b_q[28] ^ b_q[33]
                  ^ b_q[37] ^ b_q[45] ^ b_q[52] ^ b_q[60] ^ b_q[62];
  assign prod_part = (b_q[9] & b_q[15]) ^ (b_q[33] & b_q[37]) ^ (b_q[60] & b_q[63])
                   ^ (b_q[21] & b_q[28] & b_q[33]) ^ (b_q[45] & b_q[52] & b_q[60])
                   ^ (b_q[15] & b_q[21] & b_q[60] & b_q[63])
                   ^ (b_q[33] & b_q[37] & b_q[52] & b_q[60])
                   ^ (b_q[9] & b_q[28] & b_q[45] & b_q[63])
                   ^ (b_q[9] & b_q[15] & b_q[21] & b_q[28] & b_q[33])
                   ^ (b_q[37] & b_q[45] & b_q[52] & b_q[60] & b_q[63])
                   ^ (b_q[21] & b_q[28] & b_q[33] & b_q[37] & b_q[45] & b_q[52]);
  assign fb = lin_head_i ^ lin_part ^ prod_part ^ inject;
  assign fltr_tap_o = b_q[63];

  for (genvar g = 0; g < MASK_N; g++) begin : g_mask
    assign mask_o[g] = b_q[MASK_AT[g]];
  end

  always_ff @(posedge clk) begin
    if (rst)       b_q <= '0;
    else if (load) b_q <= key_i;
    else if (adv)  b_q <= {fb, b_q[W-1:1]};
  end

  AST_KEY_LOAD: assert property (@(posedge clk) disable iff (rst)
    load |=> (b_q == $past(key_i))); // R2
  AST_NL_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!load && !adv) |=> $stable(b_q)); // R7
endmodule

// File: rtl/kg_filter.sv
module kg_filter
  import kgen_pkg::*;
(
  input  logic [4:0]        x_i,
  input  logic [MASK_N-1:0] mask_i,
  output logic              z_o
);
  logic h;

  always_comb begin
    h = x_i[1] ^ x_i[4]
      ^ (x_i[0] & x_i[3]) ^ (x_i[2] & x_i[3]) ^ (x_i[3] & x_i[4])
      ^ (x_i[0] & x_i[1] & x_i[2]) ^ (x_i[0] & x_i[2] & x_i[3])
      ^ (x_i[0] & x_i[2] & x_i[4]) ^ (x_i[1] & x_i[2] & x_i[4])
      ^ (x_i[2] & x_i[3] & x_i[4]);
    z_o = h ^ (^mask_i);
  end
endmodule

// File: rtl/kstream80_gen.sv
module kstream80_gen
  import kgen_pkg::*;
#(
  parameter int unsigned STATE_W     = 80,
  parameter int unsigned IV_W        = 64,
  parameter int unsigned WARM_CYCLES = 160
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start_i,
  input  logic [STATE_W-1:0] key_i,
  input  logic [IV_W-1:0]    iv_i,
  input  logic               ready_i,
  output logic               busy_o,
  output logic               valid_o,
  output logic               bit_o
);
  localparam int unsigned CNT_W = $clog2(WARM_CYCLES);
  localparam int unsigned CHK_W = $clog2(WARM_CYCLES + 1);

  phase_t             phase_q;
  logic [CNT_W-1:0]   warm_cnt_q;
  logic               valid_q, busy_q;
  logic               accept, adv, inject, warm_last, z;
  logic               lin_head, nl_tap;
  logic [3:0]         lin_taps;
  logic [MASK_N-1:0]  mask;

  assign accept    = start_i && (phase_q != PH_WARM);
  assign adv       = !accept && ((phase_q == PH_WARM) || ((phase_q == PH_RUN) && ready_i));
  assign inject    = (phase_q == PH_WARM) && z;
  assign warm_last = (warm_cnt_q == CNT_W'(WARM_CYCLES - 1));

  kg_lin_reg #(.W(STATE_W), .IV_W(IV_W)) u_lin (
    .clk(clk), .rst(rst), .load(accept), .adv(adv), .inject(inject),
    .iv_i(iv_i), .head_o(lin_head), .taps_o(lin_taps)
  );

  kg_nl_reg #(.W(STATE_W)) u_nl (
    .clk(clk), .rst(rst), .load(accept), .adv(adv), .inject(inject),
    .lin_head_i(lin_head), .key_i(key_i), .fltr_tap_o(nl_tap), .mask_o(mask)
  );

  kg_filter u_filt (
    .x_i({nl_tap, lin_taps}), .mask_i(mask), .z_o(z)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q    <= PH_IDLE;
      warm_cnt_q <= '0;
      valid_q    <= 1'b0;
      busy_q     <= 1'b0;
    end else if (accept) begin
      phase_q    <= PH_WARM;
      warm_cnt_q <= '0;
      valid_q    <= 1'b0;
      busy_q     <= 1'b1;
    end else if (phase_q == PH_WARM) begin
      if (warm_last) begin
        phase_q <= PH_RUN;
        valid_q <= 1'b1;
        busy_q  <= 1'b0;
      end else begin
        warm_cnt_q <= warm_cnt_q + 1'b1;
      end
    end
  end

  assign busy_o  = busy_q;
  assign valid_o = valid_q;
  assign bit_o   = z;

  // Warm-up length checker: counts busy cycles since the last accepted start.
  logic [CHK_W-1:0] chk_busy_q;
  always_ff @(posedge clk) begin
    if (rst || accept)                                   chk_busy_q <= '0;
    else if (busy_o && chk_busy_q != CHK_W'(WARM_CYCLES)) chk_busy_q <= chk_busy_q + 1'b1;
  end

  AST_WARM_SPAN: assert property (@(posedge clk) disable iff (rst)
    $rose(valid_o) |-> (chk_busy_q == CHK_W'(WARM_CYCLES))); // R6
  AST_HOLD_BIT: assert property (@(posedge clk) disable iff (rst)
    (valid_o && !ready_i && !start_i) |=> (valid_o && $stable(bit_o))); // R7
  AST_BUSY_NO_RESTART: assert property (@(posedge clk) disable iff (rst)
    (busy_o && start_i) |=> (busy_o || valid_o)); // R8
  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (!valid_o && !busy_o)); // R1
endmodule

// File: tb/tb_kstream80_gen.sv
`timescale 1ns/1ps
module tb_kstream80_gen;
  logic        clk = 1'b0;
  logic        rst, start_i, ready_i;
  logic [79:0] key_i;
  logic [63:0] iv_i;
  logic        busy_o, valid_o, bit_o;

  kstream80_gen dut (
    .clk(clk), .rst(rst), .start_i(start_i), .key_i(key_i), .iv_i(iv_i),
    .ready_i(ready_i), .busy_o(busy_o), .valid_o(valid_o), .bit_o(bit_o)
  );

  always #4 clk = ~clk;

  int total = 0;
  int bad   = 0;
  logic [79:0] ms, mb;
  logic [63:0] rng = 64'h9E3779B97F4A7C15;

  task automatic chk(input bit ok, input string req, input logic [79:0] act, input logic [79:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic m_lfb(input logic [79:0] s); // R3
    return s[0] ^ s[13] ^ s[23] ^ s[38] ^ s[51] ^ s[62];
  endfunction

  function automatic logic m_nfb(input logic [79:0] b); // R4
    return b[0]^b[9]^b[14]^b[21]^b[28]^b[33]^b[37]^b[45]^b[52]^b[60]^b[62]
      ^ (b[9]&b[15]) ^ (b[33]&b[37]) ^ (b[60]&b[63])
      ^ (b[21]&b[28]&b[33]) ^ (b[45]&b[52]&b[60])
      ^ (b[15]&b[21]&b[60]&b[63]) ^ (b[33]&b[37]&b[52]&b[60]) ^ (b[9]&b[28]&b[45]&b[63])
      ^ (b[9]&b[15]&b[21]&b[28]&b[33]) ^ (b[37]&b[45]&b[52]&b[60]&b[63])
      ^ (b[21]&b[28]&b[33]&b[37]&b[45]&b[52]);
  endfunction

  function automatic logic m_z(input logic [79:0] s, input logic [79:0] b); // R5
    logic a0, a1, a2, a3, a4, h;
    a0 = s[3]; a1 = s[25]; a2 = s[46]; a3 = s[64]; a4 = b[63];
    h = a1 ^ a4 ^ (a0&a3) ^ (a2&a3) ^ (a3&a4) ^ (a0&a1&a2) ^ (a0&a2&a3)
      ^ (a0&a2&a4) ^ (a1&a2&a4) ^ (a2&a3&a4);
    return h ^ b[1] ^ b[2] ^ b[4] ^ b[10] ^ b[31] ^ b[43] ^ b[56];
  endfunction

  task automatic m_step(input bit warm); // R10: shift toward stage 0
    logic zz, nl, nn;
    zz = warm ? m_z(ms, mb) : 1'b0;
    nl = m_lfb(ms) ^ zz;
    nn = m_nfb(mb) ^ ms[0] ^ zz;
    ms = {nl, ms[79:1]};
    mb = {nn, mb[79:1]};
  endtask

  function automatic logic [63:0] next_rng(input logic [63:0] x);
    logic [63:0] y;
    y = x ^ (x << 13);
    y = y ^ (y >> 7);
    return y ^ (y << 17);
  endfunction

  // At a negedge: accept start (optionally colliding with a handshake, R9).
  task automatic do_start(input logic [79:0] k, input logic [63:0] v, input bit collide);
    start_i = 1'b1; key_i = k; iv_i = v;
    if (collide) begin
      ready_i = 1'b1;
      chk(valid_o === 1'b1, "R9", {79'd0, valid_o}, 80'd1);
      chk(bit_o === m_z(ms, mb), "R9", {79'd0, bit_o}, {79'd0, m_z(ms, mb)});
    end else ready_i = 1'b0;
    @(posedge clk);
    ms = {16'hFFFF, v}; // R2
    mb = k;
    @(negedge clk);
    start_i = 1'b0; ready_i = 1'b0;
  endtask

  // 160 warm-up cycles; an ignored start is offered at cycle poke (R8).
  task automatic warm(input int poke);
    for (int i = 0; i < 160; i++) begin
      chk(busy_o === 1'b1 && valid_o === 1'b0, "R6", {78'd0, busy_o, valid_o}, 80'd2);
      if (i == poke) begin
        start_i = 1'b1; key_i = ~key_i; iv_i = ~iv_i; ready_i = 1'b1;
      end else begin
        start_i = 1'b0; ready_i = 1'b0;
      end
      @(posedge clk);
      m_step(1'b1);
      @(negedge clk);
    end
    start_i = 1'b0;
    chk(busy_o === 1'b0 && valid_o === 1'b1, "R6", {78'd0, busy_o, valid_o}, 80'd1);
  endtask

  task automatic stream(input int n, input int mode);
    bit prev_rdy;
    prev_rdy = 1'b1;
    for (int i = 0; i < n; i++) begin
      bit rdy;
      case (mode)
        0: rdy = 1'b1;
        1: rdy = (i % 2) == 0;
        default: rdy = ((i * 7) % 5) < 2;
      endcase
      chk(valid_o === 1'b1, "R7", {79'd0, valid_o}, 80'd1);
      if (prev_rdy)
        chk(bit_o === m_z(ms, mb), "R5", {79'd0, bit_o}, {79'd0, m_z(ms, mb)});
      else
        chk(bit_o === m_z(ms, mb), "R7", {79'd0, bit_o}, {79'd0, m_z(ms, mb)});
      ready_i = rdy;
      @(posedge clk);
      if (rdy) m_step(1'b0);
      @(negedge clk);
      prev_rdy = rdy;
    end
    ready_i = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst = 1'b1; start_i = 1'b0; ready_i = 1'b0; key_i = '0; iv_i = '0;
    ms = '0; mb = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: idle after reset, ready alone does nothing
    ready_i = 1'b1;
    for (int i = 0; i < 5; i++) begin
      chk(valid_o === 1'b0 && busy_o === 1'b0, "R1", {78'd0, busy_o, valid_o}, 80'd0);
      @(negedge clk);
    end
    ready_i = 1'b0;

    // all-zero key and IV, continuous ready
    do_start(80'd0, 64'd0, 1'b0);
    warm(-1);
    stream(120, 0);

    // all-ones, alternating ready, start poked mid warm-up (R8)
    do_start({80{1'b1}}, {64{1'b1}}, 1'b0);
    warm(40);
    stream(120, 1);

    // re-key during keystream colliding with a handshake (R9)
    do_start(80'h0123_4567_89AB_CDEF_F00D, 64'hFEDC_BA98_7654_3210, 1'b1);
    warm(159); // R8: start on the last warm-up cycle is ignored
    stream(120, 2);

    // single key bit set, start poked at warm-up cycle 0 (R8)
    do_start(80'd1 << 79, 64'd1, 1'b1);
    warm(0);
    stream(80, 0);

    // pseudorandom sweep over key/IV and ready modes
    for (int r = 0; r < 6; r++) begin
      logic [79:0] k;
      logic [63:0] v;
      rng = next_rng(rng); k[63:0] = rng;
      rng = next_rng(rng); k[79:64] = rng[15:0];
      rng = next_rng(rng); v = rng;
      do_start(k, v, r[0]);
      warm(r * 25);
      stream(100, r % 3);
    end

    // reset in the middle of the stream (R1)
    stream(10, 0);
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk(valid_o === 1'b0 && busy_o === 1'b0, "R1", {78'd0, busy_o, valid_o}, 80'd0);
    rst = 1'b0; ready_i = 1'b1;
    for (int i = 0; i < 4; i++) begin
      chk(valid_o === 1'b0 && busy_o === 1'b0, "R1", {78'd0, busy_o, valid_o}, 80'd0);
      @(negedge clk);
    end
    ready_i = 1'b0;

    // after reset, a fresh start works again
    do_start(80'hA5A5_5A5A_0F0F_F0F0_3C3C, 64'h1234_5678_9ABC_DEF0, 1'b0);
    warm(-1);
    stream(60, 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule